// File: doc/BRIEF.md
# I2C Slave Address Match Detector

This block decides whether the address byte that opens an I2C transfer selects this device. A byte-assembly stage upstream shifts bits in from the data line. It hands this block each complete byte with a valid strobe and a flag marking the first byte of a transfer. It also passes on one-cycle pulses for START and STOP conditions. The block compares that address byte with a programmed 8-bit own-address value. It then keeps two sticky flags, one for an address hit and one for the general-call address. It also raises a single-cycle event that the interrupt logic can use.

Two addressing formats are handled. In the short (7-bit) format, the seven upper bits of the byte are compared with the seven upper bits of the own-address value, and the lowest bit is treated as the read/write direction and ignored. In the long (10-bit) format, only the leading byte is examined, and all eight bits must equal the own-address value, including its direction bit. An all-zero byte is a general call in either format. It raises both flags. Firmware acknowledges a hit by writing the data register. The general-call flag drops by itself at the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `addr_hit`, `gcall_hit` and `hit_evt` are all 0.
- R2: With `long_addr` = 0, a first byte whose bits [7:1] equal `own_addr[7:1]` sets `addr_hit`, whatever value byte bit 0 (the direction bit) has.
- R3: With `long_addr` = 0, a first byte that differs from `own_addr` in any of bits [7:1] and is not 8'h00 leaves `addr_hit` at 0 and raises no `hit_evt`.
- R4: A first byte of 8'h00 sets both `gcall_hit` and `addr_hit`, in either addressing format.
- R5: With `long_addr` = 1, `addr_hit` sets only when all eight bits of the first byte equal `own_addr`. A difference in bit 0 alone gives no hit.
- R6: No flag sets and no event fires while `cmp_en` = 0 or `enable` = 0.
- R7: Only one byte after each START is evaluated, and it must arrive with `first_byte` = 1. Later bytes are not evaluated until the next START. Bytes with `first_byte` = 0 are never evaluated. A STOP also ends the window.
- R8: `gcall_hit` clears in the cycle after a START or a STOP pulse. Neither pulse changes `addr_hit`.
- R9: A `dreg_wr` pulse while `enable` = 1 clears `addr_hit`. The same pulse while `enable` = 0 leaves `addr_hit` unchanged.
- R10: `hit_evt` is high for exactly one cycle: the cycle in which `addr_hit` first shows the result of the address byte.
- R11: If an address hit and a `dreg_wr` fall in the same cycle, the hit wins and `addr_hit` ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable |
| cmp_en | input | 1 | Address comparison enable |
| long_addr | input | 1 | 0: 7-bit format, 1: 10-bit format (first byte compared on all 8 bits) |
| own_addr | input | 8 | Programmed own address; bits [7:1] are the 7-bit address, all bits are used in 10-bit format |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is complete |
| first_byte | input | 1 | Marks `rx_byte` as the first byte after a START |
| start_det | input | 1 | One-cycle START or repeated START pulse |
| stop_det | input | 1 | One-cycle STOP pulse |
| dreg_wr | input | 1 | One-cycle pulse: data shift register written |
| addr_hit | output | 1 | Sticky address-match flag |
| gcall_hit | output | 1 | Sticky general-call flag |
| hit_evt | output | 1 | One-cycle match event to the interrupt logic |

## Verification
The bench targets the direction bit. A 7-bit compare that includes it would miss a read address. A 10-bit compare that drops it would accept the wrong direction. The all-zero byte is tested in both formats, because a design that only raises the general-call flag would leave the hit flag low. The bench sends a second matching byte with no new START, and a byte that arrives after a STOP. A design that evaluates every byte would raise a second event in both cases. A data-register write is issued with the module disabled, and again in the same cycle as a hit, to expose a clear that ignores the enable or beats the set.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;

  localparam int BYTE_W = 8;
  localparam int SHORT_W = BYTE_W - 1;

  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } addr_fmt_e;

  // Short format: direction bit (bit 0) takes no part in the compare.
  function automatic logic short_equal(input logic [BYTE_W-1:0] rx,
                                       input logic [BYTE_W-1:0] own);
    return rx[BYTE_W-1:1] == own[BYTE_W-1:1];
  endfunction

  // Long format leading byte: every bit including direction.
  function automatic logic long_equal(input logic [BYTE_W-1:0] rx,
                                      input logic [BYTE_W-1:0] own);
    return rx == own;
  endfunction

  function automatic logic is_general_call(input logic [BYTE_W-1:0] rx);
    return rx == '0;
  endfunction

endpackage

// File: rtl/i2c_addr_window.sv
// Tracks whether the address byte of the current transfer is still pending.
module i2c_addr_window (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic rx_valid,
  input  logic first_byte,
  output logic armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (start_det) begin
      armed <= 1'b1;
    end else if (stop_det) begin
      armed <= 1'b0;
    end else if (rx_valid && first_byte) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_addr_cmp.sv
// Combinational decision for the address byte.
module i2c_addr_cmp
  import i2c_addr_match_pkg::*;
(
  input  logic              evaluate,
  input  addr_fmt_e         fmt,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_addr,
  output logic              hit,
  output logic              gc_hit
);

  logic own_equal;
  logic gc_code;

  always_comb begin
    if (fmt == FMT_LONG) begin
      own_equal = long_equal(rx_byte, own_addr);
    end else begin
      own_equal = short_equal(rx_byte, own_addr);
    end
    gc_code = is_general_call(rx_byte);
    hit     = evaluate && (own_equal || gc_code);
    gc_hit  = evaluate && gc_code;
  end

endmodule

// File: rtl/i2c_addr_flags.sv
// Sticky result flags and the single-cycle event.
module i2c_addr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_det,
  input  logic stop_det,
  input  logic dreg_wr,
  input  logic hit,
  input  logic gc_hit,
  output logic addr_hit,
  output logic gcall_hit,
  output logic hit_evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hit <= 1'b0;
    end else if (hit) begin
      addr_hit <= 1'b1;
    end else if (dreg_wr && enable) begin
      addr_hit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcall_hit <= 1'b0;
    end else if (start_det || stop_det) begin
      gcall_hit <= 1'b0;
    end else if (gc_hit) begin
      gcall_hit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_evt <= 1'b0;
    end else begin
      hit_evt <= hit;
    end
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cmp_en,
  input  logic              long_addr,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              first_byte,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              dreg_wr,
  output logic              addr_hit,
  output logic              gcall_hit,
  output logic              hit_evt
);

  logic      armed;
  logic      evaluate;
  logic      hit_now;
  logic      gc_now;
  addr_fmt_e fmt;

  assign fmt = addr_fmt_e'(long_addr);

  // A START or STOP in the same cycle as a byte takes precedence.
  assign evaluate = rx_valid && first_byte && armed && cmp_en && enable
                    && !start_det && !stop_det;

  i2c_addr_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rx_valid   (rx_valid),
    .first_byte (first_byte),
    .armed      (armed)
  );

  i2c_addr_cmp u_cmp (
    .evaluate (evaluate),
    .fmt      (fmt),
    .rx_byte  (rx_byte),
    .own_addr (own_addr),
    .hit      (hit_now),
    .gc_hit   (gc_now)
  );

  i2c_addr_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dreg_wr   (dreg_wr),
    .hit       (hit_now),
    .gc_hit    (gc_now),
    .addr_hit  (addr_hit),
    .gcall_hit (gcall_hit),
    .hit_evt   (hit_evt)
  );

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cmp_en,
  input logic start_det,
  input logic stop_det,
  input logic dreg_wr,
  input logic hit_now,
  input logic addr_hit,
  input logic gcall_hit,
  input logic hit_evt
);

  a_r10_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> !hit_evt);

  a_r10_evt_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> addr_hit);

  a_r4_gcall_rise_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_hit) |-> hit_evt);

  a_r8_gcall_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !gcall_hit);

  a_r9_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dreg_wr && enable && !hit_now) |=> !addr_hit);

  a_r9_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && !(dreg_wr && enable)) |=> addr_hit);

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en || !enable) |=> !hit_evt);

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cmp_en    (cmp_en),
  .start_det (start_det),
  .stop_det  (stop_det),
  .dreg_wr   (dreg_wr),
  .hit_now   (hit_now),
  .addr_hit  (addr_hit),
  .gcall_hit (gcall_hit),
  .hit_evt   (hit_evt)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       cmp_en = 1'b1;
  logic       long_addr = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic       first_byte = 1'b0;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic       dreg_wr = 1'b0;
  logic       addr_hit, gcall_hit, hit_evt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_en(cmp_en),
    .long_addr(long_addr), .own_addr(own_addr), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .first_byte(first_byte), .start_det(start_det),
    .stop_det(stop_det), .dreg_wr(dreg_wr), .addr_hit(addr_hit),
    .gcall_hit(gcall_hit), .hit_evt(hit_evt)
  );

  // {long, own[7:0], byte[7:0], exp_hit, exp_gc}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'hA4, 8'hA4, 1'b1, 1'b0},  // R2 write direction
    {1'b0, 8'hA4, 8'hA5, 1'b1, 1'b0},  // R2 read direction
    {1'b0, 8'hA4, 8'hA6, 1'b0, 1'b0},  // R3 bit1 differs
    {1'b0, 8'hA4, 8'h24, 1'b0, 1'b0},  // R3 msb differs
    {1'b0, 8'hA4, 8'h00, 1'b1, 1'b1},  // R4 short format
    {1'b1, 8'hF2, 8'hF2, 1'b1, 1'b0},  // R5 exact
    {1'b1, 8'hF2, 8'hF3, 1'b0, 1'b0},  // R5 direction differs
    {1'b1, 8'hF2, 8'h00, 1'b1, 1'b1},  // R4 long format
    {1'b0, 8'h00, 8'h01, 1'b1, 1'b0}   // R2 zero address, read
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Drive strobes for one cycle (from a negedge), return at the next negedge.
  task automatic step(input logic s, input logic p, input logic v,
                      input logic f, input logic w);
    start_det = s; stop_det = p; rx_valid = v; first_byte = f; dreg_wr = w;
    @(negedge clk);
    start_det = 0; stop_det = 0; rx_valid = 0; first_byte = 0; dreg_wr = 0;
  endtask

  // START plus data write: arms the window, clears both flags.
  task automatic open_xfer();
    step(1, 0, 0, 0, 1);
  endtask

  task automatic send_first(input logic [7:0] b);
    rx_byte = b;
    step(0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 addr_hit", addr_hit, 1'b0);
    check("R1 gcall_hit", gcall_hit, 1'b0);
    check("R1 hit_evt", hit_evt, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      long_addr = VEC[i][18];
      own_addr  = VEC[i][17:10];
      open_xfer();
      send_first(VEC[i][9:2]);
      check("R2/R3/R5 vector addr_hit", addr_hit, VEC[i][1]);
      check("R4 vector gcall_hit", gcall_hit, VEC[i][0]);
      check("R10 vector hit_evt", hit_evt, VEC[i][1]);
      @(negedge clk);
      check("R10 event one cycle", hit_evt, 1'b0);
    end

    long_addr = 1'b0; own_addr = 8'hA4;

    // R6: comparison disabled / module disabled
    cmp_en = 1'b0; open_xfer(); send_first(8'hA4);
    check("R6 cmp_en=0 addr_hit", addr_hit, 1'b0);
    check("R6 cmp_en=0 hit_evt", hit_evt, 1'b0);
    cmp_en = 1'b1; open_xfer(); enable = 1'b0; send_first(8'h00);
    check("R6 enable=0 addr_hit", addr_hit, 1'b0);
    check("R6 enable=0 gcall_hit", gcall_hit, 1'b0);
    enable = 1'b1;

    // R7: second byte after a consumed first byte
    open_xfer(); send_first(8'hA4);
    check("R7 first byte hits", addr_hit, 1'b1);
    step(0, 0, 0, 0, 1);
    send_first(8'hA4);
    check("R7 second byte ignored", addr_hit, 1'b0);
    check("R7 second byte no event", hit_evt, 1'b0);
    // R7: first_byte=0 ignored, window kept
    open_xfer(); rx_byte = 8'hA4; step(0, 0, 1, 0, 0);
    check("R7 non-first byte ignored", addr_hit, 1'b0);
    send_first(8'hA4);
    check("R7 window still open", addr_hit, 1'b1);
    // R7: STOP closes window
    open_xfer(); step(0, 1, 0, 0, 0); send_first(8'hA4);
    check("R7 after STOP ignored", addr_hit, 1'b0);

    // R8: general call cleared by STOP, hit stays
    open_xfer(); send_first(8'h00);
    check("R8 gcall set", gcall_hit, 1'b1);
    step(0, 1, 0, 0, 0);
    check("R8 STOP clears gcall", gcall_hit, 1'b0);
    check("R8 STOP keeps addr_hit", addr_hit, 1'b1);
    open_xfer(); send_first(8'h00);
    step(1, 0, 0, 0, 0);
    check("R8 START clears gcall", gcall_hit, 1'b0);
    check("R8 START keeps addr_hit", addr_hit, 1'b1);

    // R9: data write clear, gated by enable
    enable = 1'b0; step(0, 0, 0, 0, 1);
    check("R9 write while disabled keeps", addr_hit, 1'b1);
    enable = 1'b1; step(0, 0, 0, 0, 1);
    check("R9 write clears", addr_hit, 1'b0);

    // R11: hit and write in same cycle
    open_xfer(); rx_byte = 8'hA5; step(0, 0, 1, 1, 1);
    check("R11 hit beats write", addr_hit, 1'b1);
    check("R11 event", hit_evt, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule